// File: doc/BRIEF.md
# Dual Interval Timer With Identification Window

This block places two independent down-counting interval timers behind a byte-addressed register port that spans a 4 KB window. Timer 0 takes the first 32-byte bank of the window and timer 1 the second. Eight read-only identification bytes sit at the top of the window. Every other location reads as zero, including the two integration-test words, which are not implemented.

Each timer counts pulses on its own clock-enable input, so the two can run at different rates (1 MHz each in the usual system). Each timer divides its pulses by 1, 16 or 256, and decrements on each divided tick. On the tick that finds the count at zero, the timer sets its status flag. It then either reloads or stops, depending on its mode. Each timer drives its own masked interrupt. A third output is high when either timer interrupt is high.

An access is a one-cycle `req_valid` strobe with `req_write` selecting the direction. Read data appears on `rsp_rdata` from the clock edge that samples the strobe and holds until the next read.

Top module: `dual_timer_window`

## Requirements
- R1: Byte offsets 0x000–0x01F reach timer 0 and 0x020–0x03F reach timer 1. The word inside a bank is chosen by offset bits [4:2], and an access to one bank leaves the other timer untouched.
- R2: A read of 0xFE0 + 4·i (i = 0..7) returns the byte i of the list 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits [7:0], with the upper bits zero. Writes there change nothing.
- R3: A read of any offset outside the two banks and the identification words returns zero, including 0xF00, 0xF04 and bank word 7. Writes outside the two banks have no effect on any register.
- R4: Read data is registered: it is updated by the clock edge that samples a read strobe and is otherwise held. After reset, each control word reads 0x20, and load, count and status read 0.
- R5: Bank words are as follows. Word 0 (0x00) is the reload value; a write also loads the count. Word 1 (0x04) is the count. Word 2 (0x08) is control. Word 3 (0x0C) is write-only and clears status. Word 4 (0x10) is raw status and word 5 (0x14) is masked status, both in bit 0. Word 6 (0x18) writes the reload value without touching the count. Words 0 and 6 both read back the reload value.
- R6: Control bits are: bit 0 one-shot, bit 1 32-bit width, bits [3:2] prescale (00 for 1, 01 for 16, 10 for 256, 11 for 1), bit 5 interrupt enable, bit 6 periodic, bit 7 run. Bit 4 and bits [31:8] are not stored and read as zero.
- R7: While running, the count falls by one per divided tick. A divided tick that finds zero sets raw status. In periodic mode the count then reloads from the reload value, giving an interval of value+1 ticks. In free-running mode (neither periodic nor one-shot) it reloads all ones of the current width.
- R8: In one-shot mode, which takes precedence over periodic, the expiry tick sets raw status, leaves the count at zero and clears the run bit.
- R9: With the width bit clear, the count and every value loaded into it are limited to the low 16 bits. The reload value register still keeps all 32 bits.
- R10: Each timer interrupt is raw status AND interrupt enable, and masked status reads the same value. The combined interrupt is the OR of the two. A write to the clear word drops raw status unless an expiry happens in the same cycle.
- R11: Each timer's prescaler counts only that timer's clock-enable pulses while it runs, and restarts from zero on every control write.
- R12: Writes to the count word are ignored. The count changes only through a running tick or a load or control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | One-cycle access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| tick_t0 | input | 1 | Timer 0 count-clock enable |
| tick_t1 | input | 1 | Timer 1 count-clock enable |
| irq_t0 | output | 1 | Timer 0 masked interrupt |
| irq_t1 | output | 1 | Timer 1 masked interrupt |
| irq_any | output | 1 | OR of both timer interrupts |

## Verification
The main check is the count register. It is swept over small reload values, both prescale settings and both timers. A bad decrement, a bad reload or a wrong prescaler shows up in the very next read of the count, or as a status bit that rises one tick early or late. Decode faults show up at once: reads of the other bank, of the identification words or of unmapped words give wrong data on the edge after the strobe. Stray writes show up in the registers they should not have reached. Interrupt masking and the OR are checked on the pins in the cycle after the status flag changes.

// File: rtl/dtw_pkg.sv
package dtw_pkg;

    localparam int NUM_TIMERS = 2;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 12;
    localparam int WORD_IDX_W = 3;
    localparam int BANK_LSB   = 5;
    localparam int ID_COUNT   = 8;

    // bank word indices, bits [4:2] of the offset
    localparam logic [WORD_IDX_W-1:0] IDX_LOAD   = 3'd0;
    localparam logic [WORD_IDX_W-1:0] IDX_VALUE  = 3'd1;
    localparam logic [WORD_IDX_W-1:0] IDX_CTRL   = 3'd2;
    localparam logic [WORD_IDX_W-1:0] IDX_CLEAR  = 3'd3;
    localparam logic [WORD_IDX_W-1:0] IDX_RAW    = 3'd4;
    localparam logic [WORD_IDX_W-1:0] IDX_MASKED = 3'd5;
    localparam logic [WORD_IDX_W-1:0] IDX_BGLOAD = 3'd6;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_BANK = 2'd1,
        SEL_ID   = 2'd2
    } win_sel_e;

    typedef struct packed {
        logic       run;
        logic       periodic;
        logic       irq_en;
        logic [1:0] presc;
        logic       wide;
        logic       oneshot;
    } tmr_ctrl_t;

    localparam tmr_ctrl_t CTRL_RESET = '{run: 1'b0, periodic: 1'b0, irq_en: 1'b1,
                                         presc: 2'b00, wide: 1'b0, oneshot: 1'b0};

    function automatic tmr_ctrl_t ctrl_unpack(input logic [7:0] w);
        tmr_ctrl_t c;
        c.run      = w[7];
        c.periodic = w[6];
        c.irq_en   = w[5];
        c.presc    = w[3:2];
        c.wide     = w[1];
        c.oneshot  = w[0];
        return c;
    endfunction

    function automatic logic [7:0] ctrl_pack(input tmr_ctrl_t c);
        return {c.run, c.periodic, c.irq_en, 1'b0, c.presc, c.wide, c.oneshot};
    endfunction

    function automatic logic [7:0] id_value(input logic [2:0] i);
        logic [7:0] b;
        case (i)
            3'd0:    b = 8'h04;
            3'd1:    b = 8'h18;
            3'd2:    b = 8'h14;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dtw_addr_decode.sv
module dtw_addr_decode
    import dtw_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int NBANKS = NUM_TIMERS
) (
    input  logic [AW-1:0]         addr,
    output win_sel_e              sel,
    output logic [$clog2(NBANKS > 1 ? NBANKS : 2)-1:0] bank_idx,
    output logic [WORD_IDX_W-1:0] word_idx
);
    localparam int BANK_W = AW - BANK_LSB;
    localparam int BIDX_W = $clog2(NBANKS > 1 ? NBANKS : 2);

    logic [BANK_W-1:0] bank_field;

    assign bank_field = addr[AW-1:BANK_LSB];
    assign word_idx   = addr[BANK_LSB-1:2];
    assign bank_idx   = bank_field[BIDX_W-1:0];

    always_comb begin
        if (32'(bank_field) < 32'(NBANKS)) begin
            sel = SEL_BANK;
        end else if (&bank_field) begin
            sel = SEL_ID;
        end else begin
            sel = SEL_NONE;
        end
    end

    logic unused_low_bits;
    assign unused_low_bits = ^addr[1:0];

endmodule

// File: rtl/dtw_id_rom.sv
module dtw_id_rom
    import dtw_pkg::*;
(
    input  logic [2:0] idx,
    output logic [7:0] id_byte
);
    assign id_byte = id_value(idx);
endmodule

// File: rtl/dtw_timer_core.sv
module dtw_timer_core
    import dtw_pkg::*;
#(
    parameter int W        = DATA_W,
    parameter int HALF_W   = 16,
    parameter int DIV_A_LG = 4,
    parameter int DIV_B_LG = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  wr_en,
    input  logic [WORD_IDX_W-1:0] idx,
    input  logic [W-1:0]          wdata,
    output logic [W-1:0]          rd_data,
    output logic                  irq
);
    localparam int PRE_W = DIV_B_LG;
    localparam logic [PRE_W-1:0] PRE_A = PRE_W'((1 << DIV_A_LG) - 1);
    localparam logic [PRE_W-1:0] PRE_B = PRE_W'((1 << DIV_B_LG) - 1);
    localparam logic [W-1:0] HALF_MASK = {{(W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

    typedef struct packed {
        tmr_ctrl_t        ctrl;
        logic [W-1:0]     limit;
        logic [W-1:0]     cnt;
        logic             raw;
        logic [PRE_W-1:0] pre;
    } core_state_t;

    core_state_t      s_d, s_q;
    logic [W-1:0]     width_mask;
    logic [PRE_W-1:0] pre_max;
    logic             pre_hit;
    logic             ptick;
    logic             expire;

    always_comb begin
        s_d        = s_q;
        width_mask = s_q.ctrl.wide ? '1 : HALF_MASK;
        case (s_q.ctrl.presc)
            2'b01:   pre_max = PRE_A;
            2'b10:   pre_max = PRE_B;
            default: pre_max = '0;
        endcase
        pre_hit = (s_q.pre == pre_max);
        ptick   = s_q.ctrl.run && tick && pre_hit;
        expire  = ptick && (s_q.cnt == '0);

        if (s_q.ctrl.run && tick) begin
            s_d.pre = pre_hit ? '0 : s_q.pre + 1'b1;
        end

        if (ptick) begin
            if (expire) begin
                s_d.raw = 1'b1;
                if (s_q.ctrl.oneshot) begin
                    s_d.ctrl.run = 1'b0;
                end else if (s_q.ctrl.periodic) begin
                    s_d.cnt = s_q.limit & width_mask;
                end else begin
                    s_d.cnt = width_mask;
                end
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end

        if (wr_en) begin
            case (idx)
                IDX_LOAD: begin
                    s_d.limit = wdata;
                    s_d.cnt   = wdata & width_mask;
                end
                IDX_CTRL: begin
                    s_d.ctrl = ctrl_unpack(wdata[7:0]);
                    s_d.pre  = '0;
                    s_d.cnt  = s_d.cnt & (wdata[1] ? '1 : HALF_MASK);
                end
                IDX_CLEAR:  s_d.raw   = expire;
                IDX_BGLOAD: s_d.limit = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ctrl  <= CTRL_RESET;
            s_q.limit <= '0;
            s_q.cnt   <= '0;
            s_q.raw   <= 1'b0;
            s_q.pre   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (idx)
            IDX_LOAD, IDX_BGLOAD: rd_data = s_q.limit;
            IDX_VALUE:            rd_data = s_q.cnt;
            IDX_CTRL:             rd_data = W'(ctrl_pack(s_q.ctrl));
            IDX_RAW:              rd_data = W'(s_q.raw);
            IDX_MASKED:           rd_data = W'(s_q.raw & s_q.ctrl.irq_en);
            default:              rd_data = '0;
        endcase
    end

    assign irq = s_q.raw & s_q.ctrl.irq_en;

    // R8
    oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && s_q.ctrl.oneshot && !wr_en) |=> (!s_q.ctrl.run && s_q.cnt == '0));

    // R12
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(tick && s_q.ctrl.run)) |=> $stable(s_q.cnt));

    // R9
    narrow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.ctrl.wide |-> ((s_q.cnt & ~HALF_MASK) == '0));

    // R10
    raw_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.raw) |-> $past(expire));

endmodule

// File: rtl/dual_timer_window.sv
module dual_timer_window
    import dtw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              tick_t0,
    input  logic              tick_t1,
    output logic              irq_t0,
    output logic              irq_t1,
    output logic              irq_any
);
    localparam int BIDX_W = $clog2(NUM_TIMERS > 1 ? NUM_TIMERS : 2);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t                top_d, top_q;
    win_sel_e                  sel;
    logic [BIDX_W-1:0]         bank_idx;
    logic [WORD_IDX_W-1:0]     word_idx;
    logic [7:0]                id_byte;
    logic [NUM_TIMERS-1:0]     tick_vec;
    logic [NUM_TIMERS-1:0]     irq_vec;
    logic [DATA_W-1:0]         core_rd [NUM_TIMERS];
    logic                      rd_req;

    assign tick_vec = {tick_t1, tick_t0};
    assign rd_req   = req_valid && !req_write;

    dtw_addr_decode #(.AW(ADDR_W), .NBANKS(NUM_TIMERS)) decode_i (
        .addr     (req_addr),
        .sel      (sel),
        .bank_idx (bank_idx),
        .word_idx (word_idx)
    );

    dtw_id_rom id_rom_i (
        .idx     (word_idx),
        .id_byte (id_byte)
    );

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_timer
        logic bank_wr;
        assign bank_wr = req_valid && req_write && (sel == SEL_BANK)
                         && (32'(bank_idx) == g);
        dtw_timer_core #(.W(DATA_W)) core_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick_vec[g]),
            .wr_en   (bank_wr),
            .idx     (word_idx),
            .wdata   (req_wdata),
            .rd_data (core_rd[g]),
            .irq     (irq_vec[g])
        );
    end

    always_comb begin
        top_d = top_q;
        if (rd_req) begin
            case (sel)
                SEL_BANK: top_d.rdata = core_rd[bank_idx];
                SEL_ID:   top_d.rdata = DATA_W'(id_byte);
                default:  top_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q.rdata <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign rsp_rdata = top_q.rdata;
    assign irq_t0    = irq_vec[0];
    assign irq_t1    = irq_vec[1];
    assign irq_any   = |irq_vec;

    // R3
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && sel == SEL_NONE) |=> (rsp_rdata == '0));

    // R2
    id_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && sel == SEL_ID) |=> (rsp_rdata[DATA_W-1:8] == '0));

    // R4
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rsp_rdata));

    // R10
    combine_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_any) |-> ($rose(irq_t0) || $rose(irq_t1)));

endmodule

// File: tb/dual_timer_window_tb_top.sv
module dual_timer_window_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        tick_t0 = 1'b0;
    logic        tick_t1 = 1'b0;
    logic        irq_t0, irq_t1, irq_any;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dual_timer_window dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .tick_t0(tick_t0), .tick_t1(tick_t1),
        .irq_t0(irq_t0), .irq_t1(irq_t1), .irq_any(irq_any)
    );

    function automatic logic [31:0] exp_id(input int i);
        case (i)
            0: return 32'h04; 1: return 32'h18; 2: return 32'h14; 3: return 32'h00;
            4: return 32'h0D; 5: return 32'hF0; 6: return 32'h05; default: return 32'hB1;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic ticks(input int t, input int n);
        if (n > 0) begin
            @(negedge clk);
            if (t == 0) tick_t0 = 1'b1; else tick_t1 = 1'b1;
            repeat (n) @(negedge clk);
            tick_t0 = 1'b0; tick_t1 = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R4 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4 reset state
        rchk("R4 t0 ctrl reset", 12'h008, 32'h20);
        rchk("R4 t1 ctrl reset", 12'h028, 32'h20);
        rchk("R4 t0 load reset", 12'h000, 32'h0);
        rchk("R4 t0 count reset", 12'h004, 32'h0);
        rchk("R4 t0 raw reset", 12'h010, 32'h0);
        chk("R4 irq_any reset", {31'b0, irq_any}, 32'h0);

        // R2 identification words
        for (int i = 0; i < 8; i++) rchk("R2 id byte", 12'hFE0 + 12'(4 * i), exp_id(i));

        // R4 registered read: data changes only after the sampling edge
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 12'hFE4;
        #1 chk("R4 rdata before edge", rsp_rdata, 32'hB1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R4 rdata after edge", rsp_rdata, 32'h18);

        // R3 unmapped reads
        rchk("R3 test ctrl", 12'hF00, 32'h0);
        rchk("R3 test out", 12'hF04, 32'h0);
        rchk("R3 past banks", 12'h040, 32'h0);
        rchk("R3 bank word 7", 12'h01C, 32'h0);
        rchk("R3 mid window", 12'h800, 32'h0);
        rchk("R3 below id", 12'hFDC, 32'h0);

        // R6 control fields
        wr(12'h008, 32'hFFFF_FFFF);
        rchk("R6 ctrl readback", 12'h008, 32'hEF);
        wr(12'h008, 32'h0);

        // R9 narrow load, R5 full reload value kept
        wr(12'h000, 32'h1234_5678);
        rchk("R9 narrow count", 12'h004, 32'h5678);
        rchk("R5 load readback", 12'h000, 32'h1234_5678);

        // R5 background load
        wr(12'h008, 32'h02);
        wr(12'h000, 32'd5);
        wr(12'h018, 32'd9);
        rchk("R5 bg load keeps count", 12'h004, 32'd5);
        rchk("R5 load word shows bg", 12'h000, 32'd9);
        rchk("R5 bg word readback", 12'h018, 32'd9);
        wr(12'h008, 32'hC2);
        ticks(0, 6);
        rchk("R5 periodic reload from bg", 12'h004, 32'd9);
        rchk("R10 raw set with irq off", 12'h010, 32'h1);
        rchk("R10 masked zero with irq off", 12'h014, 32'h0);
        chk("R10 irq_t0 masked", {31'b0, irq_t0}, 32'h0);
        wr(12'h008, 32'hE2);
        rchk("R10 masked with irq on", 12'h014, 32'h1);
        chk("R10 irq_t0 high", {31'b0, irq_t0}, 32'h1);
        chk("R10 irq_any high", {31'b0, irq_any}, 32'h1);
        wr(12'h00C, 32'h0);
        rchk("R10 clear raw", 12'h010, 32'h0);
        chk("R10 irq_any cleared", {31'b0, irq_any}, 32'h0);
        wr(12'h008, 32'h0);

        // R12 count write ignored
        wr(12'h004, 32'h77);
        rchk("R12 count unchanged", 12'h004, 32'd9);

        // R3 writes outside the banks
        wr(12'h040, 32'hDEAD);
        wr(12'hFE0, 32'hDEAD);
        wr(12'hF00, 32'hDEAD);
        rchk("R3 t0 load intact", 12'h000, 32'd9);
        rchk("R3 t1 load intact", 12'h020, 32'd0);
        rchk("R2 id not writable", 12'hFE0, 32'h04);

        // R8 one-shot, with periodic also set
        wr(12'h008, 32'h02);
        wr(12'h000, 32'd2);
        wr(12'h008, 32'hE3);
        ticks(0, 3);
        rchk("R8 oneshot count zero", 12'h004, 32'd0);
        rchk("R8 oneshot raw", 12'h010, 32'h1);
        rchk("R8 run bit cleared", 12'h008, 32'h63);
        ticks(0, 5);
        rchk("R8 stays at zero", 12'h004, 32'd0);
        wr(12'h00C, 32'h0);
        wr(12'h008, 32'h0);

        // R7 free-running, narrow and wide
        wr(12'h000, 32'd1);
        wr(12'h008, 32'h80);
        ticks(0, 2);
        rchk("R7 R9 free-run narrow wrap", 12'h004, 32'h0000_FFFF);
        rchk("R7 free-run raw", 12'h010, 32'h1);
        wr(12'h008, 32'h02);
        wr(12'h000, 32'd0);
        wr(12'h008, 32'h82);
        ticks(0, 1);
        rchk("R7 free-run wide wrap", 12'h004, 32'hFFFF_FFFF);
        wr(12'h008, 32'h0);
        wr(12'h00C, 32'h0);

        // R11 prescaler restart and independence
        wr(12'h008, 32'h02);
        wr(12'h000, 32'd5);
        wr(12'h008, 32'hC6);
        ticks(0, 10);
        wr(12'h008, 32'hC6);
        ticks(0, 10);
        rchk("R11 prescaler restarted", 12'h004, 32'd5);
        ticks(0, 6);
        rchk("R11 div16 step", 12'h004, 32'd4);
        ticks(1, 20);
        rchk("R11 other tick ignored", 12'h004, 32'd4);
        wr(12'h008, 32'h0);

        // R11 divide by 256
        wr(12'h008, 32'h02);
        wr(12'h000, 32'd0);
        wr(12'h008, 32'hCA);
        ticks(0, 255);
        rchk("R11 div256 not yet", 12'h010, 32'h0);
        ticks(0, 1);
        rchk("R11 div256 expiry", 12'h010, 32'h1);
        wr(12'h00C, 32'h0);
        wr(12'h008, 32'h0);

        // R1 timer 1 bank and combined interrupt
        wr(12'h028, 32'h02);
        wr(12'h020, 32'd0);
        wr(12'h028, 32'hE2);
        ticks(1, 1);
        rchk("R1 t1 raw", 12'h030, 32'h1);
        rchk("R1 t0 raw untouched", 12'h010, 32'h0);
        chk("R10 irq_t1", {31'b0, irq_t1}, 32'h1);
        chk("R10 irq_t0 low", {31'b0, irq_t0}, 32'h0);
        chk("R10 irq_any from t1", {31'b0, irq_any}, 32'h1);
        wr(12'h02C, 32'h0);
        chk("R10 irq_any after t1 clear", {31'b0, irq_any}, 32'h0);
        wr(12'h028, 32'h0);

        // R7 R1 periodic sweep over both timers and two prescalers
        for (int t = 0; t < 2; t++) begin
            for (int dv = 0; dv < 2; dv++) begin
                for (int lv = 0; lv <= 4; lv++) begin
                    for (int k = 0; k <= 2 * lv + 2; k++) begin
                        logic [11:0] base;
                        logic [31:0] v;
                        int          div;
                        logic        exp_raw;
                        base = 12'(t * 32);
                        div  = (dv == 1) ? 16 : 1;
                        exp_raw = (k >= lv + 1);
                        wr(base + 12'h008, 32'h0);
                        wr(base + 12'h00C, 32'h0);
                        wr(base + 12'h000, 32'(lv));
                        wr(base + 12'h008, (dv == 1) ? 32'hE6 : 32'hE2);
                        ticks(t, k * div);
                        rd(base + 12'h004, v);
                        chk("R7 sweep count", v, 32'(lv - (k % (lv + 1))));
                        rd(base + 12'h010, v);
                        chk("R7 sweep raw", v, {31'b0, exp_raw});
                        chk("R10 sweep irq pin", {31'b0, (t == 0) ? irq_t0 : irq_t1},
                            {31'b0, exp_raw});
                        chk("R1 sweep irq_any", {31'b0, irq_any}, {31'b0, exp_raw});
                    end
                end
            end
            wr(12'(t * 32) + 12'h008, 32'h0);
            wr(12'(t * 32) + 12'h00C, 32'h0);
        end

        finish_run();
    end
endmodule